// File: doc/BRIEF.md
# Four-Channel Double-Buffered DAC Register Bank

This block holds the digital side of a four-channel converter that sits behind a two-wire serial port. A serial front end, which is not part of this block, turns bus traffic into byte-level strobes: a pointer byte, a start of sequence, data bytes, and a strobe at the end of a write. Each channel has two stages. The input register takes new data. The DAC register drives the channel's output code. A pointer register chooses which channels a write affects and which channel a read returns.

A write is applied only when the write-complete strobe arrives after two data bytes, most significant byte first. The 16-bit word carries a 10-bit code and two control bits. Both control bits are active low. With the clear bit low, the whole bank goes to zero. With the load bit low, every channel's output stage is refreshed from its input stage. Reads are combinational from the registers. A pointer that names exactly one channel returns that channel's input register. Any other pointer returns a fixed default word.

Top module: `dac_quad_regbank`

## Requirements
- R1: On `ptr_we`, pointer bits [3:0] are taken from `ptr_din[3:0]`, where bit i selects channel i. Bits [7:4] are ignored. The pointer is 0 after reset.
- R2: The data word is the first data byte (bits 15:8) followed by the second data byte (bits 7:0). The layout is: clear bit at bit 13 (active low), load bit at bit 12 (active low), code at bits 11:2. Bits 15, 14, 1 and 0 are ignored.
- R3: On a valid commit with clear=1, the code goes into the input register of every channel whose pointer bit is 1. Unselected input registers keep their values.
- R4: On a valid commit with clear=0, every input register and every DAC register becomes 0. This holds whatever the pointer and load bit are.
- R5: On a valid commit with clear=1 and load=0, all four DAC registers take their channel's input register value, including data written by this same commit.
- R6: On a valid commit with clear=1 and load=1, no DAC register changes.
- R7: When exactly one pointer bit is set, the readback word is 0x2000 OR (that channel's input code shifted left by 2). `rd_msb` is bits 15:8 and `rd_lsb` is bits 7:0.
- R8: When zero pointer bits, or two or more, are set, the readback word is 0x2000.
- R9: A `wr_done` that arrives after fewer than two data bytes, counted since the last `seq_start` or `wr_done`, changes no register. Data bytes after the second one are ignored.
- R10: A pointer write in the same cycle as a valid commit does not affect that commit, which uses the previous pointer. The new pointer applies from the next cycle.
- R11: A synchronous active-high `rst` clears the pointer, all input registers and all DAC registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_we | input | 1 | Pointer byte strobe |
| ptr_din | input | 8 | Pointer byte |
| seq_start | input | 1 | Start of a transfer; clears the data byte count |
| byte_vld | input | 1 | Data byte strobe |
| byte_din | input | 8 | Data byte |
| wr_done | input | 1 | End-of-write strobe |
| rd_msb | output | 8 | Readback word, high byte |
| rd_lsb | output | 8 | Readback word, low byte |
| dac_code | output | 40 | DAC register codes; channel i at bits [10i+9:10i] |

## Verification
Two events can land in the same cycle: a pointer update and a commit. The bench drives `ptr_we` with a new pointer in the very cycle that `wr_done` closes a complete write. It then checks that the data went only to the channels the old pointer named. The new pointer is judged afterwards through readback, which must follow the new selection. A second collision is also exercised: a commit that both writes new data and refreshes the output stage. Here the bench expects the refreshed DAC register to carry the data written in that same cycle.

// File: rtl/dacq_pkg.sv
package dacq_pkg;
  parameter int NCH    = 4;
  parameter int CODE_W = 10;
  parameter int WORD_W = 16;
  parameter int BYTE_W = 8;

  localparam int CLR_POS  = WORD_W - 3;
  localparam int LD_POS   = WORD_W - 4;
  localparam int CODE_MSB = WORD_W - 5;
  localparam int CODE_LSB = CODE_MSB - CODE_W + 1;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CODE_W-1:0] code_t;

  function automatic code_t word_code(input word_t w);
    return w[CODE_MSB:CODE_LSB];
  endfunction

  function automatic logic word_clr_n(input word_t w);
    return w[CLR_POS];
  endfunction

  function automatic logic word_ld_n(input word_t w);
    return w[LD_POS];
  endfunction

  function automatic word_t default_word();
    word_t w;
    w = '0;
    w[CLR_POS] = 1'b1;
    return w;
  endfunction

  function automatic word_t readback_word(input code_t c);
    word_t w;
    w = default_word();
    w[CODE_MSB:CODE_LSB] = c;
    return w;
  endfunction

  function automatic int unsigned sel_count(input logic [NCH-1:0] s);
    int unsigned n;
    n = 0;
    for (int i = 0; i < NCH; i++) n += int'(s[i]);
    return n;
  endfunction
endpackage

// File: rtl/dacq_byte_collect.sv
module dacq_byte_collect
  import dacq_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          seq_start,
  input  logic          byte_vld,
  input  logic [BW-1:0] byte_din,
  input  logic          wr_done,
  output word_t         word_q,
  output logic          commit
);
  localparam int NBYTES = WORD_W / BW;
  localparam int CW     = $clog2(NBYTES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      word_q <= '0;
    end else if (seq_start || wr_done) begin
      cnt_q <= '0;
    end else if (byte_vld && (int'(cnt_q) < NBYTES)) begin
      word_q[WORD_W-1-int'(cnt_q)*BW -: BW] <= byte_din;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign commit = wr_done && (int'(cnt_q) == NBYTES);
endmodule

// File: rtl/dacq_chan.sv
module dacq_chan
  import dacq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sel,
  input  logic  commit,
  input  logic  clr_n,
  input  logic  ld_n,
  input  code_t code,
  output code_t in_q,
  output code_t dac_q
);
  code_t in_next;

  always_comb begin
    in_next = sel ? code : in_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q  <= '0;
      dac_q <= '0;
    end else if (commit) begin
      if (!clr_n) begin
        in_q  <= '0;
        dac_q <= '0;
      end else begin
        in_q <= in_next;
        if (!ld_n) dac_q <= in_next;
      end
    end
  end
endmodule

// File: rtl/dacq_readmux.sv
module dacq_readmux
  import dacq_pkg::*;
#(
  parameter int N = NCH
) (
  input  logic [N-1:0]        sel,
  input  logic [N*CODE_W-1:0] in_flat,
  output word_t               rd_word
);
  code_t picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < N; i++)
      if (sel[i]) picked = in_flat[i*CODE_W +: CODE_W];
    rd_word = (sel_count(sel) == 1) ? readback_word(picked) : default_word();
  end
endmodule

// File: rtl/dac_quad_regbank.sv
module dac_quad_regbank
  import dacq_pkg::*;
#(
  parameter int N  = NCH,
  parameter int BW = BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ptr_we,
  input  logic [BW-1:0]     ptr_din,
  input  logic              seq_start,
  input  logic              byte_vld,
  input  logic [BW-1:0]     byte_din,
  input  logic              wr_done,
  output logic [BW-1:0]     rd_msb,
  output logic [BW-1:0]     rd_lsb,
  output logic [N*CODE_W-1:0] dac_code
);
  logic [N-1:0]        ptr_q;
  word_t               wr_word;
  logic                commit_evt;
  logic                clr_n;
  logic                ld_n;
  code_t               wr_code;
  logic [N*CODE_W-1:0] in_flat;
  word_t               rd_word;

  always_ff @(posedge clk) begin
    if (rst)         ptr_q <= '0;
    else if (ptr_we) ptr_q <= ptr_din[N-1:0];
  end

  dacq_byte_collect #(.BW(BW)) u_collect (
    .clk      (clk),
    .rst      (rst),
    .seq_start(seq_start),
    .byte_vld (byte_vld),
    .byte_din (byte_din),
    .wr_done  (wr_done),
    .word_q   (wr_word),
    .commit   (commit_evt)
  );

  assign clr_n   = word_clr_n(wr_word);
  assign ld_n    = word_ld_n(wr_word);
  assign wr_code = word_code(wr_word);

  for (genvar g = 0; g < N; g++) begin : g_ch
    dacq_chan u_ch (
      .clk   (clk),
      .rst   (rst),
      .sel   (ptr_q[g]),
      .commit(commit_evt),
      .clr_n (clr_n),
      .ld_n  (ld_n),
      .code  (wr_code),
      .in_q  (in_flat[g*CODE_W +: CODE_W]),
      .dac_q (dac_code[g*CODE_W +: CODE_W])
    );
  end

  dacq_readmux #(.N(N)) u_rd (
    .sel    (ptr_q),
    .in_flat(in_flat),
    .rd_word(rd_word)
  );

  assign rd_msb = rd_word[WORD_W-1 -: BW];
  assign rd_lsb = rd_word[BW-1:0];
endmodule

// File: rtl/dacq_checker.sv
module dacq_checker
  import dacq_pkg::*;
#(
  parameter int N = NCH
) (
  input logic                clk,
  input logic                rst,
  input logic                commit_evt,
  input logic                clr_n,
  input logic                ld_n,
  input logic [N-1:0]        ptr_q,
  input logic [N*CODE_W-1:0] in_flat,
  input logic [N*CODE_W-1:0] dac_code,
  input word_t               rd_word
);
  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (commit_evt && !clr_n) |=> (dac_code == '0 && in_flat == '0));

  assert_xfer_R5: assert property (@(posedge clk) disable iff (rst)
    (commit_evt && clr_n && !ld_n) |=> (dac_code == in_flat));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (commit_evt && clr_n && ld_n) |=> $stable(dac_code));

  assert_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !commit_evt |=> ($stable(dac_code) && $stable(in_flat)));

  assert_single_R7: assert property (@(posedge clk) disable iff (rst)
    ($countones(ptr_q) == 1) |-> (rd_word[CLR_POS] && !rd_word[LD_POS]));

  assert_default_R8: assert property (@(posedge clk) disable iff (rst)
    ($countones(ptr_q) != 1) |-> (rd_word == default_word()));
endmodule

bind dac_quad_regbank dacq_checker #(.N(N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .commit_evt(commit_evt),
  .clr_n     (clr_n),
  .ld_n      (ld_n),
  .ptr_q     (ptr_q),
  .in_flat   (in_flat),
  .dac_code  (dac_code),
  .rd_word   (rd_word)
);

// File: tb/dac_quad_regbank_test.sv
module dac_quad_regbank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ptr_we = 1'b0;
  logic [7:0]  ptr_din = '0;
  logic        seq_start = 1'b0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_din = '0;
  logic        wr_done = 1'b0;
  logic [7:0]  rd_msb, rd_lsb;
  logic [39:0] dac_code;

  int checks = 0;
  int errors = 0;

  logic [9:0] m_in  [4];
  logic [9:0] m_dac [4];
  logic [3:0] m_ptr;

  always #2 clk = ~clk;

  dac_quad_regbank uut (
    .clk(clk), .rst(rst), .ptr_we(ptr_we), .ptr_din(ptr_din),
    .seq_start(seq_start), .byte_vld(byte_vld), .byte_din(byte_din),
    .wr_done(wr_done), .rd_msb(rd_msb), .rd_lsb(rd_lsb), .dac_code(dac_code)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rb(input logic [3:0] p);
    int n = 0;
    int idx = 0;
    for (int i = 0; i < 4; i++) if (p[i]) begin n++; idx = i; end
    if (n == 1) return 16'h2000 | ({6'd0, m_in[idx]} << 2);
    return 16'h2000;
  endfunction

  task automatic check_dacs(input string tag);
    for (int i = 0; i < 4; i++)
      chk(tag, {6'd0, dac_code[i*10 +: 10]}, {6'd0, m_dac[i]});
  endtask

  task automatic ptr_write(input logic [7:0] b);
    @(negedge clk); ptr_we = 1'b1; ptr_din = b;
    @(negedge clk); ptr_we = 1'b0;
    m_ptr = b[3:0];
  endtask

  task automatic check_rb(input string tag, input logic [7:0] b);
    ptr_write(b);
    chk(tag, {rd_msb, rd_lsb}, exp_rb(b[3:0]));
  endtask

  task automatic check_all_rb(input string tag);
    for (int i = 0; i < 4; i++) check_rb(tag, 8'(1 << i));
  endtask

  task automatic send_bytes(input logic [15:0] w, input int nbytes);
    @(negedge clk); seq_start = 1'b1;
    @(negedge clk); seq_start = 1'b0;
    for (int k = 0; k < nbytes; k++) begin
      byte_vld = 1'b1;
      byte_din = (k == 0) ? w[15:8] : (k == 1) ? w[7:0] : 8'hA5;
      @(negedge clk);
    end
    byte_vld = 1'b0;
  endtask

  task automatic model_apply(input logic [15:0] w, input logic [3:0] p);
    if (!w[13]) begin
      for (int i = 0; i < 4; i++) begin m_in[i] = '0; m_dac[i] = '0; end
    end else begin
      for (int i = 0; i < 4; i++) if (p[i]) m_in[i] = w[11:2];
      if (!w[12]) for (int i = 0; i < 4; i++) m_dac[i] = m_in[i];
    end
  endtask

  task automatic full_write(input logic [7:0] pb, input logic [15:0] w);
    ptr_write(pb);
    send_bytes(w, 2);
    wr_done = 1'b1;
    @(negedge clk); wr_done = 1'b0;
    model_apply(w, pb[3:0]);
  endtask

  task automatic t_reset();
    check_dacs("R11 reset dacs");
    chk("R1 R8 reset pointer default readback", {rd_msb, rd_lsb}, 16'h2000);
    check_all_rb("R11 reset inputs");
  endtask

  task automatic t_hold();
    full_write(8'h01, 16'h3000 | (16'h155 << 2));
    check_dacs("R6 load bit high keeps dacs");
    check_all_rb("R3 R7 single write readback");
  endtask

  task automatic t_load();
    full_write(8'h04, 16'h2000 | (16'h2AA << 2));
    check_dacs("R5 load bit low refreshes all dacs");
    check_all_rb("R3 load write inputs");
  endtask

  task automatic t_multi();
    full_write(8'hFB, 16'h3000 | (16'h3FF << 2));
    check_all_rb("R1 R3 multi write upper ptr bits ignored");
    check_rb("R8 two channels default", 8'h03);
    check_rb("R8 all channels default", 8'h0F);
    check_dacs("R6 multi write dacs held");
  endtask

  task automatic t_ignored_bits();
    full_write(8'h02, 16'hE003 | (16'h0C3 << 2));
    check_all_rb("R2 ignored word bits");
    check_dacs("R2 R5 refresh with ignored bits");
  endtask

  task automatic t_clear();
    full_write(8'h00, 16'h1000 | (16'h111 << 2));
    check_dacs("R4 clear dacs");
    check_all_rb("R4 clear inputs");
  endtask

  task automatic t_truncated();
    full_write(8'h08, 16'h2000 | (16'h201 << 2));
    ptr_write(8'h01);
    send_bytes(16'h2000 | (16'h0AA << 2), 1);
    wr_done = 1'b1;
    @(negedge clk); wr_done = 1'b0;
    check_dacs("R9 short write dacs unchanged");
    check_all_rb("R9 short write inputs unchanged");
    ptr_write(8'h02);
    send_bytes(16'h2000 | (16'h123 << 2), 3);
    wr_done = 1'b1;
    @(negedge clk); wr_done = 1'b0;
    model_apply(16'h2000 | (16'h123 << 2), 4'h2);
    check_dacs("R9 extra byte ignored dacs");
    check_all_rb("R9 extra byte ignored inputs");
  endtask

  task automatic t_collision();
    ptr_write(8'h01);
    send_bytes(16'h3000 | (16'h077 << 2), 2);
    ptr_we = 1'b1; ptr_din = 8'h08; wr_done = 1'b1;
    @(negedge clk); ptr_we = 1'b0; wr_done = 1'b0;
    model_apply(16'h3000 | (16'h077 << 2), 4'h1);
    m_ptr = 4'h8;
    chk("R10 new pointer after collision", {rd_msb, rd_lsb}, exp_rb(4'h8));
    check_all_rb("R10 commit used old pointer");
  endtask

  task automatic t_rst_again();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 4; i++) begin m_in[i] = '0; m_dac[i] = '0; end
    m_ptr = '0;
    chk("R11 reset pointer", {rd_msb, rd_lsb}, 16'h2000);
    check_dacs("R11 reset dacs again");
    check_all_rb("R11 reset inputs again");
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_in[i] = '0; m_dac[i] = '0; end
    m_ptr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_hold();
    t_load();
    t_multi();
    t_ignored_bits();
    t_clear();
    t_truncated();
    t_collision();
    t_rst_again();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule